// File: doc/BRIEF.md
# Transposing Slice Buffer for a Distributed-Arithmetic Inverse Transform

This block sits between an inverse-quantization stage and a distributed-arithmetic inverse transform. The upstream stage hands over a group of eight 16-bit coefficients, one word per accepted cycle. The transform wants the same data sideways: narrow slices made of one bit position taken from four neighbouring words. Each slice serves as the address of a lookup ROM.

Writes fill a group row by row. Once a group is complete, a read pass walks the bit positions from LSB to MSB. For each bit position it gives one 4-bit slice from words 0..3, then one slice from words 4..7, so a group yields 32 slices. There are two storage banks used in alternation. A new group can therefore be written while the previous one is being sliced out. Back-pressure stops the writer when both banks hold unread groups.

Top module: `slice_transpose_buf`

## Requirements
- R1: After synchronous reset, in_ready is 1, and out_avail, out_valid and out_last are 0. out_slice is 0.
- R2: A word is taken only in a cycle with in_valid and in_ready both high. Accepted words are numbered 0..7 in arrival order. A group is complete only after its eighth accepted word, and out_avail stays 0 before that.
- R3: out_avail reads 1 in the cycle that follows the clock edge that accepted the eighth word of a group, provided no read pass is in progress.
- R4: out_start sampled while out_avail is 1 makes out_valid high from the next cycle for exactly 32 consecutive cycles. out_avail is 0 while out_valid is 1.
- R5: The n-th slice of a pass (n = 0..31) uses bit position n/2 and half n%2. Bit k of the slice (k = 0..3, with bit 0 as the LSB) is bit n/2 of word 4*(n%2)+k of the group. out_slice is 0 whenever out_valid is 0.
- R6: out_last is 1 together with the 32nd slice of a pass and at no other time. out_valid is 0 in the cycle after out_last.
- R7: out_start has no effect while out_avail is 0. This covers an empty buffer and a pass that is already running.
- R8: Two complete groups can be held at once. While both are unread, in_ready is 0, in_valid has no effect, and both stored groups are read back unchanged.
- R9: When a stalled writer waits on the bank that is being read, in_ready is 1 in the cycle after out_last. Groups are read out in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A coefficient word is offered |
| in_data | input | 16 | Coefficient word |
| in_ready | output | 1 | Write bank has room; word accepted when in_valid is also high |
| out_avail | output | 1 | A complete unread group waits and no pass is running |
| out_start | input | 1 | Begin a read pass; ignored unless out_avail is high |
| out_slice | output | 4 | Bit-slice used as the ROM address |
| out_valid | output | 1 | out_slice holds a slice of the current pass |
| out_last | output | 1 | Final slice of the pass |

## Verification
The two functions that can coincide are the release of a bank by the final slice of a pass and a write into that same bank. The bench fills both banks and then holds in_valid high on the next word, so that the writer stalls. While a pass runs, it checks that in_ready is still 0 beside out_last and becomes 1 one cycle later. The word that was held is then read back in the next group but one, which shows it was neither lost nor written early. Later sweeps write and read continuously in parallel, so that group completion in one bank and slicing of the other overlap on arbitrary cycles. Every slice is compared with the bit-select arithmetic of R5.

// File: rtl/tbuf_pkg.sv
// Package: shared constants and types for the transposing slice buffer.
// Assumes two banks in ping-pong use; the bank pointer is a single bit.
package tbuf_pkg;
    localparam int TB_BANKS = 2;
    typedef logic bank_t;
endpackage

// File: rtl/tbuf_bank.sv
// Module: one storage bank. Holds NUM_WORDS words written by index and
// returns a SLICE_W-bit slice: one bit position across SLICE_W consecutive
// words starting at word half_sel*SLICE_W. Assumes NUM_WORDS is a multiple
// of SLICE_W. Storage needs no reset: it is only read after a full group.
module tbuf_bank #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 8,
    parameter int SLICE_W   = 4,
    localparam int HALVES   = NUM_WORDS / SLICE_W,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int HALF_W   = $clog2(HALVES),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [WIDX_W-1:0]   widx,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [HALF_W-1:0]   half_sel,
    input  logic [BIT_W-1:0]    bit_sel,
    output logic [SLICE_W-1:0]  slice
);
    logic [WORD_W-1:0] mem [NUM_WORDS];

    // Store an accepted word at its arrival index.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Gather one bit position across SLICE_W words of the selected half.
    always_comb begin
        for (int k = 0; k < SLICE_W; k++) begin
            slice[k] = mem[int'(half_sel) * SLICE_W + k][bit_sel];
        end
    end
endmodule

// File: rtl/tbuf_wr_ctl.sv
// Module: write side. It counts words in a group and selects the bank.
// It raises grp_done with the eighth accepted word. Assumes the owner
// sets the bank-full flag on grp_done and clears it when the reader
// releases the bank.
module tbuf_wr_ctl
    import tbuf_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [TB_BANKS-1:0]  bank_full,
    output logic                 in_ready,
    output logic [TB_BANKS-1:0]  wr_en,
    output logic [WIDX_W-1:0]    widx,
    output logic                 grp_done,
    output bank_t                wbank
);
    logic accept;
    logic idx_end;

    assign in_ready = !bank_full[wbank];
    assign accept   = in_valid && in_ready;
    assign idx_end  = (widx == WIDX_W'(NUM_WORDS - 1));
    assign grp_done = accept && idx_end;

    // One write enable per bank, raised only for the bank being filled.
    for (genvar b = 0; b < TB_BANKS; b++) begin : g_wen
        assign wr_en[b] = accept && (wbank == bank_t'(b));
    end

    // Advance the word index; at the group end, wrap it and swap banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            widx  <= '0;
            wbank <= 1'b0;
        end else if (accept) begin
            if (idx_end) begin
                widx  <= '0;
                wbank <= ~wbank;
            end else begin
                widx <= widx + 1'b1;
            end
        end
    end

    // A refused word leaves the write position untouched.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> ($stable(widx) && $stable(wbank)));
endmodule

// File: rtl/tbuf_rd_seq.sv
// Module: read side. It runs a pass of SLICES slices over the read bank.
// The slice counter splits into a half select (low bits) and a bit
// position (high bits). Assumes the half count is a power of two, at least 2.
module tbuf_rd_seq
    import tbuf_pkg::*;
#(
    parameter int SLICES    = 32,
    localparam int CNT_W    = $clog2(SLICES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_start,
    input  logic [TB_BANKS-1:0]  bank_full,
    output logic                 busy,
    output logic                 avail,
    output logic                 last,
    output logic                 release_bank,
    output logic [CNT_W-1:0]     cnt,
    output bank_t                rbank
);
    assign avail        = bank_full[rbank] && !busy;
    assign last         = busy && (cnt == CNT_W'(SLICES - 1));
    assign release_bank = last;

    // Start a pass on request, step the counter, end after the final slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            rbank <= 1'b0;
        end else if (busy) begin
            if (last) begin
                busy  <= 1'b0;
                cnt   <= '0;
                rbank <= ~rbank;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (out_start && avail) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    p_run_continues_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !avail && out_start) |=> !busy);
    p_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
endmodule

// File: rtl/slice_transpose_buf.sv
// Module: top of the transposing slice buffer. It takes words row-wise
// into one of two banks and emits bit-slices column-wise from the other.
// It holds the per-bank full flags shared by the write and read sides.
// Assumes NUM_WORDS / SLICE_W is a power of two, at least 2.
module slice_transpose_buf
    import tbuf_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 8,
    parameter int SLICE_W   = 4,
    localparam int HALVES   = NUM_WORDS / SLICE_W,
    localparam int SLICES   = WORD_W * HALVES,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int HALF_W   = $clog2(HALVES),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int CNT_W    = $clog2(SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_avail,
    input  logic               out_start,
    output logic [SLICE_W-1:0] out_slice,
    output logic               out_valid,
    output logic               out_last
);
    logic [TB_BANKS-1:0] bank_full;
    logic [TB_BANKS-1:0] wr_en;
    logic [WIDX_W-1:0]   widx;
    logic                grp_done;
    bank_t               wbank;
    bank_t               rbank;
    logic                release_bank;
    logic [CNT_W-1:0]    cnt;
    logic [SLICE_W-1:0]  bank_slice [TB_BANKS];

    tbuf_wr_ctl #(.NUM_WORDS(NUM_WORDS)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .bank_full (bank_full),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .widx      (widx),
        .grp_done  (grp_done),
        .wbank     (wbank)
    );

    tbuf_rd_seq #(.SLICES(SLICES)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .out_start    (out_start),
        .bank_full    (bank_full),
        .busy         (out_valid),
        .avail        (out_avail),
        .last         (out_last),
        .release_bank (release_bank),
        .cnt          (cnt),
        .rbank        (rbank)
    );

    // Storage banks; both decode the same slice position.
    for (genvar b = 0; b < TB_BANKS; b++) begin : g_bank
        tbuf_bank #(
            .WORD_W    (WORD_W),
            .NUM_WORDS (NUM_WORDS),
            .SLICE_W   (SLICE_W)
        ) u_bank (
            .clk      (clk),
            .we       (wr_en[b]),
            .widx     (widx),
            .wdata    (in_data),
            .half_sel (cnt[HALF_W-1:0]),
            .bit_sel  (cnt[CNT_W-1:HALF_W]),
            .slice    (bank_slice[b])
        );

        // Per-bank full flag: set when its group completes, cleared on release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_full[b] <= 1'b0;
            end else if (grp_done && (wbank == bank_t'(b))) begin
                bank_full[b] <= 1'b1;
            end else if (release_bank && (rbank == bank_t'(b))) begin
                bank_full[b] <= 1'b0;
            end
        end
    end

    assign out_slice = out_valid ? bank_slice[rbank] : '0;

    p_last_only_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    p_avail_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_avail |-> !out_valid);
    p_ready_after_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_last && !in_ready) |=> in_ready);
    p_slice_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_slice == '0));
endmodule

// File: tb/slice_transpose_buf_bench.sv
module slice_transpose_buf_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        out_avail;
    logic        out_start = 1'b0;
    logic [3:0]  out_slice;
    logic        out_valid;
    logic        out_last;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slice_transpose_buf u_slice_transpose_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_avail (out_avail),
        .out_start (out_start),
        .out_slice (out_slice),
        .out_valid (out_valid),
        .out_last  (out_last)
    );

    // Word i of group g, computed from the group number.
    function automatic logic [15:0] pat(input int g, input int i);
        case (g)
            0: pat = 16'h0001 << (2 * i);
            1: pat = ~(16'h0002 << (2 * i));
            2: pat = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
            default: pat = 16'((g * 16'h3A7) + (i * 16'h1F1) + 16'h55) ^ 16'((i * g) << 5);
        endcase
    endfunction

    function automatic logic [3:0] exp_slice(input int g, input int n);
        logic [3:0] s;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] w;
            w = pat(g, 4 * (n % 2) + k);
            s[k] = w[n / 2];
        end
        return s;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    // Offer one word; returns at the negedge after it was accepted.
    task automatic push(input logic [15:0] w);
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic write_grp(input int g);
        for (int i = 0; i < 8; i++) push(pat(g, i));
    endtask

    // One read pass of group g; poke pulses out_start mid-pass, chk_rdy checks R9.
    task automatic read_grp(input int g, input int poke, input bit chk_rdy);
        while (!out_avail) @(negedge clk);
        out_start = 1'b1;
        @(negedge clk);
        out_start = 1'b0;
        for (int n = 0; n < 32; n++) begin
            out_start = (n == poke);
            chk("R4 valid run", int'(out_valid), 1);
            chk("R4 avail low in pass", int'(out_avail), 0);
            chk("R5 slice", int'(out_slice), int'(exp_slice(g, n)));
            chk("R6 last flag", int'(out_last), int'(n == 31));
            if (chk_rdy && n == 31) chk("R9 ready low at last", int'(in_ready), 0);
            @(negedge clk);
        end
        out_start = 1'b0;
        chk("R6 valid ends", int'(out_valid), 0);
        if (chk_rdy) chk("R9 ready after last", int'(in_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_avail", int'(out_avail), 0);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_last", int'(out_last), 0);
        chk("R1 out_slice", int'(out_slice), 0);

        // R7: start on an empty buffer is ignored
        out_start = 1'b1;
        @(negedge clk);
        out_start = 1'b0;
        chk("R7 empty start", int'(out_valid), 0);

        // R2/R3: group of eight
        for (int i = 0; i < 7; i++) push(pat(0, i));
        chk("R2 not complete at seven", int'(out_avail), 0);
        push(pat(0, 7));
        chk("R3 avail after eighth", int'(out_avail), 1);
        read_grp(0, -1, 1'b0);

        // R8: fill both banks, then the writer stalls
        write_grp(1);
        write_grp(2);
        chk("R8 ready low with both full", int'(in_ready), 0);
        fork
            write_grp(3);
            begin
                repeat (4) @(negedge clk);
                chk("R8 still refused", int'(in_ready), 0);
                read_grp(1, 10, 1'b1);
                chk("R7 mid-pass start ignored", int'(out_valid), 0);
                chk("R7 next group waiting", int'(out_avail), 1);
                read_grp(2, -1, 1'b0);
                read_grp(3, -1, 1'b0);
            end
        join

        // R9 sweep: continuous overlapped writes and reads
        fork
            for (int g = 4; g < 14; g++) write_grp(g);
            for (int g = 4; g < 14; g++) read_grp(g, (g % 3 == 0) ? g : -1, 1'b0);
        join
        chk("R1 idle after sweep", int'(out_avail), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule